// File: doc/BRIEF.md
# Flash Status Register Write-Protect Controller

This block sits between the command decoder of a serial flash and its array and status logic. It holds the write-protection fields of the status register: a sticky write-disable bit, a top/bottom select and a 4-bit protect level. Each program, erase or status-write command it is offered gets one decision: it goes ahead or it is refused. A status write that goes ahead also loads new protection fields.

The protect level and the top/bottom select mark off a run of 64 KB sectors at one end of a 256-sector array. A level of 0 protects nothing. A level n from 1 to 8 protects 2^(n-1) sectors. A level of 9 or more protects the whole array. The write-protect pin and the sticky disable bit choose between two modes. In software mode the fields can be rewritten. In hardware mode they are frozen. Clearing the write-enable latch after a command is left to the surrounding logic.

Top module: `sr_wprot_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `prot_q` is 0 and `cmd_go` and `cmd_deny` are low.
- R2: A command with `cmd_valid` high in cycle t and `cmd_kind` of 1 (program, any width), 2 (subsector erase), 3 (sector erase), 4 (bulk erase) or 5 (status write) raises exactly one of `cmd_go` or `cmd_deny` for cycle t+1 only. Kinds 0, 6 and 7 raise neither and leave `prot_q` unchanged.
- R3: With `wel` low, every command of kinds 1 to 5 is denied.
- R4: Hardware mode is `wp_n` low and `prot_q[5]` (the disable bit) set. In that mode a status write is denied and `prot_q` keeps its value.
- R5: In software mode (`wp_n` high or `prot_q[5]` clear), a status write with `wel` high is accepted and copies `prot_wdata` into `prot_q`. The field layout is [5] disable bit, [4] bottom select, [3:0] protect level.
- R6: With `prot_q[4]` = 0 and level n from 1 to 8, kinds 1 to 3 are denied for sectors at or above 256 - 2^(n-1) and accepted for lower sectors when `wel` is high.
- R7: With `prot_q[4]` = 1 and level n from 1 to 8, kinds 1 to 3 are denied for sectors below 2^(n-1) and accepted above that.
- R8: Level 0 protects no sector. A level of 9 to 15 protects every sector, whatever the bottom select.
- R9: Bulk erase with `wel` high is accepted only when the level is 0.
- R10: A denied command never changes `prot_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_n | input | 1 | Write-protect pin; low allows hardware mode |
| wel | input | 1 | Write-enable latch state |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_kind | input | 3 | Command class, encoded as in R2 |
| cmd_sector | input | SECT_BITS | Sector index of the target address (address bits 23:16) |
| prot_wdata | input | 6 | New protection fields carried by a status write |
| cmd_go | output | 1 | One-cycle pulse: command accepted |
| cmd_deny | output | 1 | One-cycle pulse: command refused |
| prot_q | output | 6 | Protection fields: disable bit, bottom select, level |

## Verification
The assertions check on every cycle that:
- the two decision pulses never coincide and appear only after a command of a checked kind;
- a cleared write-enable latch or hardware mode forces a refusal;
- a refusal leaves the fields untouched;
- bulk erase is refused while any level is set.

Only the bench's scenarios show where the protected region falls: its size for each level, which end of the array it covers, and how far the level saturates. The bench compares the accept/refuse outcomes against its own model of sector ranges, under directed edge sectors and random traffic.

// File: rtl/sr_wprot_ctrl.sv
module sr_wprot_ctrl #(
  parameter int SECT_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wp_n,
  input  logic                 wel,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_kind,
  input  logic [SECT_BITS-1:0] cmd_sector,
  input  logic [5:0]           prot_wdata,
  output logic                 cmd_go,
  output logic                 cmd_deny,
  output logic [5:0]           prot_q
);
  localparam int CW = SECT_BITS + 1;
  localparam int NSECT = 1 << SECT_BITS;
  localparam logic [2:0] K_PROG = 3'd1, K_SSE = 3'd2, K_SE = 3'd3, K_BE = 3'd4, K_WSR = 3'd5;

  wire       lock_bit = prot_q[5];
  wire       bottom   = prot_q[4];
  wire [3:0] level    = prot_q[3:0];

  logic [CW-1:0] span;
  always_comb begin
    if (level == 4'd0)
      span = '0;
    else if (int'(level) > SECT_BITS)
      span = CW'(NSECT);
    else
      span = CW'(1) << (level - 4'd1);
  end

  wire [CW-1:0] sec_w   = {1'b0, cmd_sector};
  wire          hit     = bottom ? (sec_w < span) : (sec_w >= CW'(NSECT) - span);
  wire          hw_mode = !wp_n && lock_bit;

  wire is_area  = (cmd_kind == K_PROG) || (cmd_kind == K_SSE) || (cmd_kind == K_SE);
  wire is_bulk  = (cmd_kind == K_BE);
  wire is_wsr   = (cmd_kind == K_WSR);
  wire checked  = is_area || is_bulk || is_wsr;

  wire allow = wel && ((is_area && !hit) ||
                       (is_bulk && level == 4'd0) ||
                       (is_wsr && !hw_mode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_go   <= 1'b0;
      cmd_deny <= 1'b0;
      prot_q   <= '0;
    end else begin
      cmd_go   <= cmd_valid && checked && allow;
      cmd_deny <= cmd_valid && checked && !allow;
      if (cmd_valid && is_wsr && allow)
        prot_q <= prot_wdata;
    end
  end
endmodule

// File: rtl/sr_wprot_chk.sv
module sr_wprot_chk #(
  parameter int SECT_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wp_n,
  input logic                 wel,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_kind,
  input logic [SECT_BITS-1:0] cmd_sector,
  input logic [5:0]           prot_wdata,
  input logic                 cmd_go,
  input logic                 cmd_deny,
  input logic [5:0]           prot_q
);
  wire chk_kind = (cmd_kind >= 3'd1) && (cmd_kind <= 3'd5);

  // R2
  one_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_go, cmd_deny}));

  // R2
  decision_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && chk_kind) |=> (cmd_go || cmd_deny));

  // R2
  no_spurious_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && chk_kind) |=> !(cmd_go || cmd_deny));

  // R3
  wel_clear_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && chk_kind && !wel) |=> cmd_deny);

  // R4
  hw_mode_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 3'd5 && !wp_n && prot_q[5]) |=> (cmd_deny && $stable(prot_q)));

  // R9
  bulk_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 3'd4 && prot_q[3:0] != 4'd0) |=> cmd_deny);

  // R10
  deny_keeps_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_deny |-> $stable(prot_q));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (prot_q == 6'd0 && !cmd_go && !cmd_deny));
endmodule

bind sr_wprot_ctrl sr_wprot_chk #(.SECT_BITS(SECT_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wel(wel), .cmd_valid(cmd_valid),
  .cmd_kind(cmd_kind), .cmd_sector(cmd_sector), .prot_wdata(prot_wdata),
  .cmd_go(cmd_go), .cmd_deny(cmd_deny), .prot_q(prot_q)
);

// File: tb/test_sr_wprot_ctrl.sv
module test_sr_wprot_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp_n = 1'b1;
  logic       wel = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_kind = 3'd0;
  logic [7:0] cmd_sector = 8'd0;
  logic [5:0] prot_wdata = 6'd0;
  logic       cmd_go, cmd_deny;
  logic [5:0] prot_q;

  int checks = 0;
  int errors = 0;
  logic [5:0] model = 6'd0;

  sr_wprot_ctrl i_sr_wprot_ctrl (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wel(wel), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_sector(cmd_sector), .prot_wdata(prot_wdata),
    .cmd_go(cmd_go), .cmd_deny(cmd_deny), .prot_q(prot_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit is_prot(input logic [5:0] f, input int sec);
    int lv = int'(f[3:0]);
    int n;
    if (lv == 0) return 1'b0;
    if (lv > 8) return 1'b1;
    n = 1 << (lv - 1);
    return f[4] ? (sec < n) : (sec >= 256 - n);
  endfunction

  // returns {checked, allowed}
  function automatic logic [1:0] expect_dec(input logic [2:0] k, input int sec,
                                            input bit we, input bit wp, input logic [5:0] f);
    case (k)
      3'd1, 3'd2, 3'd3: return {1'b1, we && !is_prot(f, sec)};
      3'd4:             return {1'b1, we && f[3:0] == 4'd0};
      3'd5:             return {1'b1, we && !(!wp && f[5])};
      default:          return 2'b00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic [2:0] k, input int sec,
                       input bit we, input bit wp, input logic [5:0] d);
    logic [1:0] e;
    e = expect_dec(k, sec, we, wp, model);
    cmd_valid = 1'b1; cmd_kind = k; cmd_sector = 8'(sec);
    wel = we; wp_n = wp; prot_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (e[1] && e[0] && k == 3'd5) model = d;
    check(req, {6'd0, cmd_go, cmd_deny}, {6'd0, e[1] && e[0], e[1] && !e[0]});
    check(req, {2'd0, prot_q}, {2'd0, model});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    check("R1", {cmd_go, cmd_deny, prot_q}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {cmd_go, cmd_deny, prot_q}, 8'd0);

    // R2: unchecked kinds
    issue("R2", 3'd0, 5, 1, 1, 6'h3f);
    issue("R2", 3'd6, 5, 1, 1, 6'h3f);
    issue("R2", 3'd7, 5, 1, 1, 6'h3f);
    // R3: write enable clear
    issue("R3", 3'd5, 0, 0, 1, 6'h01);
    issue("R3", 3'd1, 0, 0, 1, 6'h00);
    issue("R3", 3'd4, 0, 0, 1, 6'h00);
    // R9: bulk erase with nothing protected
    issue("R9", 3'd4, 0, 1, 1, 6'h00);
    // R5/R6: top, level 1
    issue("R5", 3'd5, 0, 1, 1, 6'h01);
    issue("R6", 3'd1, 255, 1, 1, 6'h00);
    issue("R6", 3'd2, 254, 1, 1, 6'h00);
    issue("R9", 3'd4, 0, 1, 1, 6'h00);
    // R6: top, level 8
    issue("R5", 3'd5, 0, 1, 1, 6'h08);
    issue("R6", 3'd3, 128, 1, 1, 6'h00);
    issue("R6", 3'd3, 127, 1, 1, 6'h00);
    // R7: bottom, level 2
    issue("R5", 3'd5, 0, 1, 1, 6'h12);
    issue("R7", 3'd1, 1, 1, 1, 6'h00);
    issue("R7", 3'd1, 2, 1, 1, 6'h00);
    issue("R7", 3'd2, 255, 1, 1, 6'h00);
    // R8: saturated and zero levels
    issue("R5", 3'd5, 0, 1, 1, 6'h09);
    issue("R8", 3'd1, 0, 1, 1, 6'h00);
    issue("R8", 3'd1, 255, 1, 1, 6'h00);
    issue("R5", 3'd5, 0, 1, 1, 6'h1f);
    issue("R8", 3'd3, 128, 1, 1, 6'h00);
    issue("R5", 3'd5, 0, 1, 1, 6'h10);
    issue("R8", 3'd1, 0, 1, 1, 6'h00);
    issue("R8", 3'd1, 255, 1, 1, 6'h00);
    // R4: hardware mode
    issue("R5", 3'd5, 0, 1, 1, 6'h23);
    issue("R4", 3'd5, 0, 1, 0, 6'h00);
    issue("R10", 3'd1, 255, 1, 0, 6'h00);
    issue("R4", 3'd5, 0, 1, 1, 6'h00);

    // R2 random traffic
    for (int i = 0; i < 400; i++) begin
      logic [2:0] k;
      k = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) k = 3'd5;
      issue("R2", k, int'($urandom_range(0, 255)), bit'($urandom_range(0, 7) != 0),
            bit'($urandom_range(0, 1)), 6'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule